// File: doc/BRIEF.md
# Floating-Point Sign-Copy and Conditional-Move Unit

This unit computes the new value of one 64-bit floating-point destination register for the operations that only rearrange or select bits. It takes two operands, A and B, together with the value the destination holds now and a 4-bit operation code. It returns the value to write and a write-enable. No arithmetic is performed.

The sign-copy group builds the result from selected fields of A and B. Plain copy takes A's sign. Negated copy takes the inverse of A's sign. Sign-and-exponent copy takes both A's sign and A's exponent. In each case the remaining low bits come from B.

The conditional-move group tests A against zero and writes B when the test holds. Only A's sign bit and its magnitude (every bit below the sign) are examined. A magnitude of zero counts as zero whatever the sign, so negative zero passes the EQ, GE and LE tests.

The result and the write-enable are registered once inside the unit. Operands presented before a rising clock edge therefore show up at the outputs just after that edge.

Top module: `fp_sign_cmov_unit`

## Requirements
- R1: When rst_n is low at a rising edge, dest_new becomes all zeros and dest_we becomes 0. Otherwise both outputs take, at each rising edge, the result computed from the inputs sampled at that edge (one cycle of latency).
- R2: Op code 0 (copy sign) yields A[63] followed by B[62:0].
- R3: Op code 1 (copy negated sign) yields the inverse of A[63] followed by B[62:0].
- R4: Op code 2 (copy sign and exponent) yields A[63:52] followed by B[51:0].
- R5: A is zero when A[62:0] is all zeros, whatever the value of A[63]. A[63]=1 marks A as negative.
- R6: Op code 3 (EQ) moves when A is zero. Op code 4 (NE) moves when A is not zero.
- R7: Op code 5 (GE) moves when A is non-negative or zero. Op code 6 (LE) moves when A is negative or zero.
- R8: Op code 7 (GT) moves only when A is non-negative and not zero. Op code 8 (LT) moves only when A is negative and not zero.
- R9: When a conditional move passes, dest_new is B and dest_we is 1. When it fails, dest_new is dest_cur and dest_we is 0.
- R10: dest_we is 1 for every sign-copy operation (op codes 0 to 2).
- R11: Op codes 9 to 15 are inert: dest_new is dest_cur and dest_we is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Operation code (0-2 sign copy, 3-8 conditional move, 9-15 inert) |
| opnd_a | input | 64 | Operand A: sign source and value tested against zero |
| opnd_b | input | 64 | Operand B: magnitude source and value moved |
| dest_cur | input | 64 | Current value held by the destination register |
| dest_new | output | 64 | Registered new value for the destination |
| dest_we | output | 1 | Registered write-enable for the destination |

## Verification
The assertions check on every cycle that the fields of the result follow the registered operands for each sign-copy code. They also check that sign copies always write, that a failing or inert operation returns the old destination value with the enable low, and that a zero-magnitude A always passes EQ whatever its sign.

The exact decision for each of the six conditions across the sign-and-magnitude corners is shown only by the bench's scenarios. Those corners are positive zero, negative zero, the smallest non-zero magnitudes and all-ones values. The same is true of the reset values and of the one-cycle timing, which the bench compares against its own model.

// File: rtl/fpsc_pkg.sv
// Package: shared operation codes for the sign-copy / conditional-move unit.
// Assumes a 4-bit operation field; codes above OP_CMOVLT are inert.
package fpsc_pkg;
    typedef enum logic [3:0] {
        OP_CPYS   = 4'd0,
        OP_CPYSN  = 4'd1,
        OP_CPYSE  = 4'd2,
        OP_CMOVEQ = 4'd3,
        OP_CMOVNE = 4'd4,
        OP_CMOVGE = 4'd5,
        OP_CMOVLE = 4'd6,
        OP_CMOVGT = 4'd7,
        OP_CMOVLT = 4'd8
    } fpsc_op_e;

    localparam int unsigned OP_W = 4;
endpackage

// File: rtl/fpsc_classify.sv
// Module: fpsc_classify
// Derives the zero and negative flags of a floating-point bit pattern.
// Assumes the sign sits in the top bit; zero ignores the sign entirely.
module fpsc_classify #(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] value,
    output logic             is_zero,
    output logic             is_neg
);
    localparam int unsigned SIGN_BIT = WIDTH - 1;

    // Flags: magnitude all-zero test and raw sign.
    always_comb begin
        is_zero = (value[SIGN_BIT-1:0] == '0);
        is_neg  = value[SIGN_BIT];
    end
endmodule

// File: rtl/fpsc_sign_merge.sv
// Module: fpsc_sign_merge
// Builds the sign-copy results from the fields of A and B.
// Assumes sign on the top bit with an EXP_W-bit exponent right below it.
module fpsc_sign_merge #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned EXP_W = 11
) (
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             is_copy,
    output logic [WIDTH-1:0] merged
);
    import fpsc_pkg::*;

    localparam int unsigned SIGN_BIT = WIDTH - 1;
    localparam int unsigned FRAC_W   = WIDTH - 1 - EXP_W;

    // Select which high fields come from A for each sign-copy code.
    always_comb begin
        is_copy = 1'b1;
        merged  = b;
        case (op)
            OP_CPYS:  merged = {a[SIGN_BIT], b[SIGN_BIT-1:0]};
            OP_CPYSN: merged = {~a[SIGN_BIT], b[SIGN_BIT-1:0]};
            OP_CPYSE: merged = {a[SIGN_BIT:FRAC_W], b[FRAC_W-1:0]};
            default: begin
                is_copy = 1'b0;
                merged  = b;
            end
        endcase
    end
endmodule

// File: rtl/fpsc_cond_eval.sv
// Module: fpsc_cond_eval
// Evaluates the six conditional-move tests from the zero and sign flags.
// Assumes the flags come from fpsc_classify; non-move codes give is_cmov=0.
module fpsc_cond_eval (
    input  logic [3:0] op,
    input  logic       is_zero,
    input  logic       is_neg,
    output logic       is_cmov,
    output logic       take
);
    import fpsc_pkg::*;

    // Condition table for the move codes.
    always_comb begin
        is_cmov = 1'b1;
        take    = 1'b0;
        case (op)
            OP_CMOVEQ: take = is_zero;
            OP_CMOVNE: take = !is_zero;
            OP_CMOVGE: take = !is_neg || is_zero;
            OP_CMOVLE: take = is_neg || is_zero;
            OP_CMOVGT: take = !is_neg && !is_zero;
            OP_CMOVLT: take = is_neg && !is_zero;
            default: begin
                is_cmov = 1'b0;
                take    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fp_sign_cmov_unit.sv
// Module: fp_sign_cmov_unit
// Top of the sign-copy / conditional-move datapath with one output register.
// Assumes op_sel is stable around the rising edge; unknown codes are inert.
module fp_sign_cmov_unit #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned EXP_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [WIDTH-1:0] dest_cur,
    output logic [WIDTH-1:0] dest_new,
    output logic             dest_we
);
    import fpsc_pkg::*;

    localparam int unsigned SIGN_BIT = WIDTH - 1;
    localparam int unsigned FRAC_W   = WIDTH - 1 - EXP_W;

    logic             a_zero;
    logic             a_neg;
    logic             copy_hit;
    logic [WIDTH-1:0] copy_val;
    logic             cmov_hit;
    logic             cmov_take;
    logic [WIDTH-1:0] nxt_val;
    logic             nxt_we;

    fpsc_classify #(.WIDTH(WIDTH)) u_classify (
        .value   (opnd_a),
        .is_zero (a_zero),
        .is_neg  (a_neg)
    );

    fpsc_sign_merge #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_merge (
        .op      (op_sel),
        .a       (opnd_a),
        .b       (opnd_b),
        .is_copy (copy_hit),
        .merged  (copy_val)
    );

    fpsc_cond_eval u_cond (
        .op      (op_sel),
        .is_zero (a_zero),
        .is_neg  (a_neg),
        .is_cmov (cmov_hit),
        .take    (cmov_take)
    );

    // Pick the next destination value and enable from the two groups.
    always_comb begin
        nxt_val = dest_cur;
        nxt_we  = 1'b0;
        if (copy_hit) begin
            nxt_val = copy_val;
            nxt_we  = 1'b1;
        end else if (cmov_hit && cmov_take) begin
            nxt_val = opnd_b;
            nxt_we  = 1'b1;
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_new <= '0;
            dest_we  <= 1'b0;
        end else begin
            dest_new <= nxt_val;
            dest_we  <= nxt_we;
        end
    end

    // R2: copy sign takes A's sign and B's lower bits
    a_r2_cpys_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_sel == OP_CPYS) |=>
        (dest_new[SIGN_BIT] == $past(opnd_a[SIGN_BIT]) &&
         dest_new[SIGN_BIT-1:0] == $past(opnd_b[SIGN_BIT-1:0])));

    // R3: negated copy inverts A's sign
    a_r3_cpysn_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_sel == OP_CPYSN) |=>
        (dest_new[SIGN_BIT] != $past(opnd_a[SIGN_BIT]) &&
         dest_new[SIGN_BIT-1:0] == $past(opnd_b[SIGN_BIT-1:0])));

    // R4: sign and exponent from A, fraction from B
    a_r4_cpyse_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_sel == OP_CPYSE) |=>
        (dest_new[SIGN_BIT:FRAC_W] == $past(opnd_a[SIGN_BIT:FRAC_W]) &&
         dest_new[FRAC_W-1:0] == $past(opnd_b[FRAC_W-1:0])));

    // R10: every sign copy writes
    a_r10_copy_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_sel <= OP_CPYSE) |=> dest_we);

    // R5 R6: zero magnitude passes EQ regardless of sign
    a_r5_eq_ignores_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_sel == OP_CMOVEQ && opnd_a[SIGN_BIT-1:0] == '0) |=>
        (dest_we && dest_new == $past(opnd_b)));

    // R9 R11: no write means the old destination is passed through
    a_r9_hold_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_sel > OP_CPYSE) |=>
        (dest_we ? (dest_new == $past(opnd_b)) : (dest_new == $past(dest_cur))));

    // R11: inert codes never write
    a_r11_inert_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_sel > OP_CMOVLT) |=> !dest_we);
endmodule

// File: tb/fp_sign_cmov_unit_bench.sv
module fp_sign_cmov_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [63:0] dest_cur = '0;
    logic [63:0] dest_new;
    logic        dest_we;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5ns clk = ~clk;

    fp_sign_cmov_unit u_fp_sign_cmov_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_sel   (op_sel),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .dest_cur (dest_cur),
        .dest_new (dest_new),
        .dest_we  (dest_we)
    );

    // Reference model written from the requirements.
    function automatic logic [64:0] model(input logic [3:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] d);
        logic z, n, t;
        z = (a[62:0] == 63'd0);
        n = a[63];
        t = 1'b0;
        case (op)
            4'd0: return {1'b1, a[63], b[62:0]};
            4'd1: return {1'b1, ~a[63], b[62:0]};
            4'd2: return {1'b1, a[63:52], b[51:0]};
            4'd3: t = z;
            4'd4: t = !z;
            4'd5: t = !n || z;
            4'd6: t = n || z;
            4'd7: t = !n && !z;
            4'd8: t = n && !z;
            default: t = 1'b0;
        endcase
        return t ? {1'b1, b} : {1'b0, d};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3, 4'd4: return "R6";
            4'd5, 4'd6: return "R7";
            4'd7, 4'd8: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] av, input logic aw,
                         input logic [63:0] ev, input logic ew);
        n_cmp++;
        if (av !== ev || aw !== ew) begin
            n_bad++;
            $display("FAIL %s: got val=%h we=%b, expected val=%h we=%b", tag, av, aw, ev, ew);
        end
    endtask

    // Apply one operation at a falling edge and check after the next rising edge.
    task automatic run_op(input string tag, input logic [3:0] op, input logic [63:0] a,
                          input logic [63:0] b, input logic [63:0] d);
        logic [64:0] e;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; dest_cur = d;
        e = model(op, a, b, d);
        @(negedge clk);
        check(tag, dest_new, dest_we, e[63:0], e[64]);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        logic [63:0] pz, nz, pt, nt, bv, dv;
        void'($urandom(32'd1234));
        pz = 64'h0; nz = 64'h8000_0000_0000_0000;
        pt = 64'h0000_0000_0000_0001; nt = 64'h8000_0000_0000_0001;
        bv = 64'hA5A5_1234_5678_9ABC; dv = 64'h0F0F_F0F0_3C3C_C3C3;

        // R1: reset state with active inputs
        op_sel = 4'd0; opnd_a = nt; opnd_b = bv;
        repeat (3) @(negedge clk);
        check("R1", dest_new, dest_we, 64'h0, 1'b0);
        rst_n = 1'b1;

        // R2 R3 R4 R10: directed sign copies
        run_op("R2", 4'd0, nz, 64'h7FFF_FFFF_FFFF_FFFF, dv);
        run_op("R3", 4'd1, nz, 64'hFFFF_FFFF_FFFF_FFFF, dv);
        run_op("R3", 4'd1, pz, 64'h0, dv);
        run_op("R4", 4'd2, 64'hFFF0_0000_0000_0000, 64'h000F_FFFF_FFFF_FFFF, dv);
        run_op("R10", 4'd2, 64'h0, 64'h0, dv);

        // R5: zero corners on every condition
        for (int op = 3; op <= 8; op++) begin
            run_op("R5", 4'(op), pz, bv, dv);
            run_op("R5", 4'(op), nz, bv, dv);
            run_op("R9", 4'(op), pt, bv, dv);
            run_op("R9", 4'(op), nt, bv, dv);
            run_op(tag_of(4'(op)), 4'(op), 64'hFFFF_FFFF_FFFF_FFFF, bv, dv);
            run_op(tag_of(4'(op)), 4'(op), 64'h7FFF_FFFF_FFFF_FFFF, bv, dv);
        end

        // R11: inert codes pass the destination through
        for (int op = 9; op <= 15; op++) run_op("R11", 4'(op), pz, bv, dv);

        // Random mix, with frequent zero magnitudes.
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] op;
            logic [63:0] a;
            op = 4'($urandom_range(0, 15));
            a = rnd64();
            if ($urandom_range(0, 3) == 0) a[62:0] = '0;
            run_op(tag_of(op), op, a, rnd64(), rnd64());
        end

        // R1: mid-run reset clears a pending write
        @(negedge clk);
        op_sel = 4'd0; opnd_a = nt; opnd_b = bv; rst_n = 1'b0;
        @(negedge clk);
        check("R1", dest_new, dest_we, 64'h0, 1'b0);
        rst_n = 1'b1;
        run_op("R1", 4'd3, nz, bv, dv);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule